// File: doc/BRIEF.md
# Nested Priority Exception Sequencer

This block runs exception entry and exception return for a small processor core. Peripherals and internal sources raise request bits. Each request line has its own programmable priority, where a larger value is more urgent. The block keeps the requests pending and picks the most urgent one. It compares that winner with the core's current operating priority and, when the winner is strictly more urgent, starts an entry sequence. The entry sequence first stores a three-word context frame on a descending stack in memory. It then reads the handler address from a vector table and hands that address to the core as the new program counter. At the same time it raises the operating priority and switches the core to privileged mode.

When the running handler finishes, the core pulses a return request. The block then reads the frame back in reverse order. It hands the saved program counter and status word to the core, and it restores the saved operating priority and mode. Because the priority and mode are stored in every frame, handlers can preempt one another to any depth that the stack window allows. A frame that would not fit in that window raises a sticky error flag instead of being pushed.

Top module: `exc_sequencer`

## Requirements
- R1: A pending exception is accepted only when its priority is strictly greater than the operating priority. Otherwise it stays pending. The operating priority is 0 out of reset, so a line with priority 0 is never taken.
- R2: When several exceptions are pending, the one with the largest priority wins. On a tie, the lowest exception number wins.
- R3: Entry writes three words below the stack pointer SP, in this order: the current PC at SP-4, the status word at SP-8, and a meta word at SP-12. In the meta word, bit 31 holds the previous mode (1 = privileged) and bits [PRIO_W-1:0] hold the previous operating priority. Only after these writes does the block read the vector table, and only after that read does the PC change.
- R4: The handler address is read from vec_base_i + (16 + n) * 4 for exception number n. It appears on pc_o together with a one-cycle pulse on pc_load_o.
- R5: On entry, priv_o becomes 1 and op_prio_o becomes the priority of the accepted exception.
- R6: On return with a non-empty stack, the block reads the meta word at SP, the status word at SP+4 and the PC at SP+8. It then presents the PC on pc_o and the status word on status_o, with pc_load_o and status_load_o pulsed in the same cycle, and restores op_prio_o and priv_o from the meta word.
- R7: A return request while the stack is empty is ignored: no memory access takes place, busy_o stays low, and no load pulse appears.
- R8: A pending exception with higher priority preempts a running handler and nests a new frame. One with equal priority does not preempt.
- R9: A request pulse that arrives while a sequence is running is remembered and is arbitrated once the sequence ends. The pending bit of an exception is cleared when that exception is accepted, so it is not taken again after its handler returns.
- R10: If pushing a frame would move SP below SP_LIMIT, ovf_err_o is set and the exception is not accepted. The flag stays set until reset, and while it is set no exception is accepted. Return sequences still run.
- R11: busy_o is high from the cycle after acceptance until the sequence ends, and memory requests occur only while busy_o is high. A request is held stable until mem_ready_i is high. With mem_ready_i held high, an entry is busy for 4 cycles and a return for 3.
- R12: After reset: busy_o=0, op_prio_o=0, priv_o=0, ovf_err_o=0, mem_req_o=0 and pc_load_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | N_EXC | Request pulses, one per exception number |
| exc_prio_i | input | N_EXC*PRIO_W | Priority of each exception, where line n occupies bits [n*PRIO_W +: PRIO_W] |
| vec_base_i | input | AW | Base address of the vector region |
| ret_req_i | input | 1 | Return-from-handler pulse |
| cur_pc_i | input | 32 | PC of the core, saved on entry |
| cur_status_i | input | 32 | Status word of the core, saved on entry |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Access completes in a cycle where both mem_req_o and this signal are high |
| mem_rdata_i | input | 32 | Read data, valid when mem_ready_i is high |
| pc_load_o | output | 1 | One-cycle pulse: load pc_o into the PC |
| pc_o | output | 32 | New PC |
| status_load_o | output | 1 | One-cycle pulse: load status_o, on return only |
| status_o | output | 32 | Restored status word |
| op_prio_o | output | PRIO_W | Operating priority |
| priv_o | output | 1 | Operating mode, 1 = privileged |
| busy_o | output | 1 | An entry or return sequence is in progress |
| ovf_err_o | output | 1 | Sticky stack overflow flag |

## Verification
Some properties are checked on every cycle:
- Every entry raises op_prio_o above its previous value and leaves the core privileged.
- Every PC load directly follows a completed memory read.
- A memory request waiting for ready holds its address and direction.
- Memory traffic happens only while busy.
- The overflow flag never clears on its own.
- Status loads coincide with PC loads once the block is idle.

Other behaviour only the bench scenarios can show:
- Which exception wins arbitration, including the tie-break.
- The exact frame addresses and contents.
- The vector address arithmetic.
- The values restored across several nested levels.
- That a request latched mid-sequence is taken afterwards.
- That equal priority does not preempt.
- The exact point at which the stack window refuses a frame.

// File: rtl/exc_seq_pkg.sv
// Shared types and constants for the exception sequencer.
// Assumes a 32-bit machine word for PC, status and frame words.
package exc_seq_pkg;
    localparam int XLEN        = 32;
    localparam int FRAME_WORDS = 3;    // PC, status, meta
    localparam int VEC_SKIP    = 16;   // reserved slots ahead of the vector table
    localparam int MODE_BIT    = 31;   // previous-mode bit inside the meta word

    typedef enum logic [1:0] {
        S_IDLE,
        S_PUSH,
        S_VEC,
        S_POP
    } seq_state_e;
endpackage

// File: rtl/exc_pending.sv
// Pending request register: one sticky bit per exception number.
// Assumes requests are pulses; a set in the same cycle as a clear wins.
module exc_pending #(
    parameter int N_EXC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXC-1:0] req_i,
    input  logic [N_EXC-1:0] clr_i,
    output logic [N_EXC-1:0] pend_o
);
    logic [N_EXC-1:0] pend_q;

    // Hold each request until the sequencer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | req_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/exc_arbiter.sv
// Combinational arbiter: picks the pending exception with the largest
// priority; on equal priority the lowest number wins.
// Assumes priorities arrive packed, line n at bits [n*PRIO_W +: PRIO_W].
module exc_arbiter #(
    parameter int N_EXC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic [N_EXC-1:0]        pend_i,
    input  logic [N_EXC*PRIO_W-1:0] prio_flat_i,
    output logic                    win_vld_o,
    output logic [ID_W-1:0]         win_id_o,
    output logic [PRIO_W-1:0]       win_prio_o
);
    logic [PRIO_W-1:0] prio_arr [N_EXC];

    genvar g;
    generate
        for (g = 0; g < N_EXC; g++) begin : g_unpack
            assign prio_arr[g] = prio_flat_i[g*PRIO_W +: PRIO_W];
        end
    endgenerate

    // Linear scan; strict compare keeps the earliest (lowest) number on ties.
    always_comb begin
        win_vld_o  = 1'b0;
        win_id_o   = '0;
        win_prio_o = '0;
        for (int i = 0; i < N_EXC; i++) begin
            if (pend_i[i] && (!win_vld_o || prio_arr[i] > win_prio_o)) begin
                win_vld_o  = 1'b1;
                win_id_o   = ID_W'(i);
                win_prio_o = prio_arr[i];
            end
        end
    end
endmodule

// File: rtl/exc_frame_ctrl.sv
// Frame sequencer: owns the stack pointer and the memory port.
// Entry: three writes below SP (PC, status, meta), then one vector read.
// Return: three reads upward from SP (meta, status, PC).
// Assumes start_entry_i / start_ret_i are only raised while idle.
module exc_frame_ctrl
    import exc_seq_pkg::*;
#(
    parameter int          PRIO_W   = 3,
    parameter int          ID_W     = 3,
    parameter int          AW       = 32,
    parameter int unsigned SP_TOP   = 32'h100,
    parameter int unsigned SP_LIMIT = 32'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_entry_i,
    input  logic              start_ret_i,
    input  logic [ID_W-1:0]   exc_id_i,
    input  logic [PRIO_W-1:0] exc_prio_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic [XLEN-1:0]   cur_status_i,
    input  logic [PRIO_W-1:0] cur_prio_i,
    input  logic              cur_priv_i,
    input  logic [AW-1:0]     vec_base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [XLEN-1:0]   mem_rdata_i,
    output logic              busy_o,
    output logic              room_o,
    output logic              stacked_o,
    output logic              done_entry_o,
    output logic              done_ret_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [PRIO_W-1:0] entry_prio_o,
    output logic [XLEN-1:0]   ret_status_o,
    output logic [PRIO_W-1:0] ret_prio_o,
    output logic              ret_priv_o
);
    localparam logic [AW-1:0] FRAME_BYTES = AW'(FRAME_WORDS * 4);
    localparam logic [AW-1:0] TOP_A       = AW'(SP_TOP);
    localparam logic [AW-1:0] LIM_A       = AW'(SP_LIMIT);
    localparam logic [1:0]    LAST_BEAT   = 2'(FRAME_WORDS - 1);

    seq_state_e        state_q;
    logic [1:0]        beat_q;
    logic [AW-1:0]     sp_q;
    logic [ID_W-1:0]   id_q;
    logic [PRIO_W-1:0] prio_q;
    logic [XLEN-1:0]   sv_pc_q;
    logic [XLEN-1:0]   sv_st_q;
    logic [XLEN-1:0]   sv_meta_q;
    logic [XLEN-1:0]   rd_st_q;
    logic [PRIO_W-1:0] rd_prio_q;
    logic              rd_priv_q;
    logic [XLEN-1:0]   meta_w;
    logic [XLEN-1:0]   push_word;
    logic [AW-1:0]     vec_addr;

    // Pack the previous priority and mode into the meta word.
    always_comb begin
        meta_w                 = '0;
        meta_w[MODE_BIT]       = cur_priv_i;
        meta_w[PRIO_W-1:0]     = cur_prio_i;
    end

    // Select which saved word the current push beat writes.
    always_comb begin
        case (beat_q)
            2'd0:    push_word = sv_pc_q;
            2'd1:    push_word = sv_st_q;
            default: push_word = sv_meta_q;
        endcase
    end

    // Vector slot address: base plus (reserved slots + number) words.
    assign vec_addr = vec_base_i + ((AW'(VEC_SKIP) + AW'(id_q)) << 2);

    // Sequence state, beat counter, stack pointer and captured frame data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            beat_q    <= '0;
            sp_q      <= TOP_A;
            id_q      <= '0;
            prio_q    <= '0;
            sv_pc_q   <= '0;
            sv_st_q   <= '0;
            sv_meta_q <= '0;
            rd_st_q   <= '0;
            rd_prio_q <= '0;
            rd_priv_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    beat_q <= '0;
                    if (start_entry_i) begin
                        id_q      <= exc_id_i;
                        prio_q    <= exc_prio_i;
                        sv_pc_q   <= cur_pc_i;
                        sv_st_q   <= cur_status_i;
                        sv_meta_q <= meta_w;
                        state_q   <= S_PUSH;
                    end else if (start_ret_i) begin
                        state_q <= S_POP;
                    end
                end
                S_PUSH: begin
                    if (mem_ready_i) begin
                        if (beat_q == LAST_BEAT) begin
                            beat_q  <= '0;
                            state_q <= S_VEC;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                        end
                    end
                end
                S_VEC: begin
                    if (mem_ready_i) begin
                        sp_q    <= sp_q - FRAME_BYTES;
                        state_q <= S_IDLE;
                    end
                end
                S_POP: begin
                    if (mem_ready_i) begin
                        case (beat_q)
                            2'd0: begin
                                rd_prio_q <= mem_rdata_i[PRIO_W-1:0];
                                rd_priv_q <= mem_rdata_i[MODE_BIT];
                            end
                            2'd1:    rd_st_q <= mem_rdata_i;
                            default: ;
                        endcase
                        if (beat_q == LAST_BEAT) begin
                            beat_q  <= '0;
                            sp_q    <= sp_q + FRAME_BYTES;
                            state_q <= S_IDLE;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port from the state and beat.
    always_comb begin
        mem_req_o   = (state_q != S_IDLE);
        mem_we_o    = (state_q == S_PUSH);
        mem_wdata_o = (state_q == S_PUSH) ? push_word : '0;
        case (state_q)
            S_PUSH:  mem_addr_o = sp_q - ((AW'(beat_q) + AW'(1)) << 2);
            S_VEC:   mem_addr_o = vec_addr;
            S_POP:   mem_addr_o = sp_q + (AW'(beat_q) << 2);
            default: mem_addr_o = '0;
        endcase
    end

    assign busy_o       = (state_q != S_IDLE);
    assign room_o       = (sp_q >= LIM_A + FRAME_BYTES);
    assign stacked_o    = (sp_q != TOP_A);
    assign done_entry_o = (state_q == S_VEC) && mem_ready_i;
    assign done_ret_o   = (state_q == S_POP) && mem_ready_i && (beat_q == LAST_BEAT);
    assign new_pc_o     = mem_rdata_i;
    assign entry_prio_o = prio_q;
    assign ret_status_o = rd_st_q;
    assign ret_prio_o   = rd_prio_q;
    assign ret_priv_o   = rd_priv_q;
endmodule

// File: rtl/exc_sequencer.sv
// Top of the exception sequencer: pending bits, arbitration, the accept
// decision, the overflow flag and the core-facing state (PC, status,
// priority, mode). Assumes a larger priority value is more urgent and
// that the core applies pc_o / status_o on their load pulses.
module exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int          N_EXC    = 8,
    parameter int          PRIO_W   = 3,
    parameter int          AW       = 32,
    parameter int unsigned SP_TOP   = 32'h100,
    parameter int unsigned SP_LIMIT = 32'hD0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXC-1:0]        exc_req_i,
    input  logic [N_EXC*PRIO_W-1:0] exc_prio_i,
    input  logic [AW-1:0]           vec_base_i,
    input  logic                    ret_req_i,
    input  logic [31:0]             cur_pc_i,
    input  logic [31:0]             cur_status_i,
    output logic                    mem_req_o,
    output logic                    mem_we_o,
    output logic [AW-1:0]           mem_addr_o,
    output logic [31:0]             mem_wdata_o,
    input  logic                    mem_ready_i,
    input  logic [31:0]             mem_rdata_i,
    output logic                    pc_load_o,
    output logic [31:0]             pc_o,
    output logic                    status_load_o,
    output logic [31:0]             status_o,
    output logic [PRIO_W-1:0]       op_prio_o,
    output logic                    priv_o,
    output logic                    busy_o,
    output logic                    ovf_err_o
);
    localparam int ID_W = (N_EXC > 1) ? $clog2(N_EXC) : 1;

    logic [N_EXC-1:0]  pend;
    logic [N_EXC-1:0]  clr;
    logic              win_vld;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              busy;
    logic              room;
    logic              stacked;
    logic              done_entry;
    logic              done_ret;
    logic [31:0]       new_pc;
    logic [PRIO_W-1:0] entry_prio;
    logic [31:0]       ret_status;
    logic [PRIO_W-1:0] ret_prio;
    logic              ret_priv;
    logic              take_ret;
    logic              eligible;
    logic              accept;
    logic              ovf_set;

    logic [PRIO_W-1:0] op_prio_q;
    logic              priv_q;
    logic [31:0]       pc_q;
    logic [31:0]       status_q;
    logic              pc_load_q;
    logic              status_load_q;
    logic              ovf_q;

    exc_pending #(.N_EXC(N_EXC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (exc_req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    exc_arbiter #(.N_EXC(N_EXC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .pend_i      (pend),
        .prio_flat_i (exc_prio_i),
        .win_vld_o   (win_vld),
        .win_id_o    (win_id),
        .win_prio_o  (win_prio)
    );

    // Decide between return, entry and overflow while idle; return goes first.
    always_comb begin
        take_ret = ret_req_i && !busy && stacked;
        eligible = win_vld && (win_prio > op_prio_q) && !ovf_q && !busy && !take_ret;
        accept   = eligible && room;
        ovf_set  = eligible && !room;
        clr      = accept ? (N_EXC'(1) << win_id) : '0;
    end

    exc_frame_ctrl #(
        .PRIO_W   (PRIO_W),
        .ID_W     (ID_W),
        .AW       (AW),
        .SP_TOP   (SP_TOP),
        .SP_LIMIT (SP_LIMIT)
    ) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_entry_i (accept),
        .start_ret_i   (take_ret),
        .exc_id_i      (win_id),
        .exc_prio_i    (win_prio),
        .cur_pc_i      (cur_pc_i),
        .cur_status_i  (cur_status_i),
        .cur_prio_i    (op_prio_q),
        .cur_priv_i    (priv_q),
        .vec_base_i    (vec_base_i),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_ready_i   (mem_ready_i),
        .mem_rdata_i   (mem_rdata_i),
        .busy_o        (busy),
        .room_o        (room),
        .stacked_o     (stacked),
        .done_entry_o  (done_entry),
        .done_ret_o    (done_ret),
        .new_pc_o      (new_pc),
        .entry_prio_o  (entry_prio),
        .ret_status_o  (ret_status),
        .ret_prio_o    (ret_prio),
        .ret_priv_o    (ret_priv)
    );

    // Core-facing state: update priority, mode, PC and status at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_prio_q     <= '0;
            priv_q        <= 1'b0;
            pc_q          <= '0;
            status_q      <= '0;
            pc_load_q     <= 1'b0;
            status_load_q <= 1'b0;
            ovf_q         <= 1'b0;
        end else begin
            pc_load_q     <= 1'b0;
            status_load_q <= 1'b0;
            if (ovf_set) ovf_q <= 1'b1;
            if (done_entry) begin
                pc_q      <= new_pc;
                op_prio_q <= entry_prio;
                priv_q    <= 1'b1;
                pc_load_q <= 1'b1;
            end else if (done_ret) begin
                pc_q          <= new_pc;
                status_q      <= ret_status;
                op_prio_q     <= ret_prio;
                priv_q        <= ret_priv;
                pc_load_q     <= 1'b1;
                status_load_q <= 1'b1;
            end
        end
    end

    assign busy_o        = busy;
    assign pc_load_o     = pc_load_q;
    assign pc_o          = pc_q;
    assign status_load_o = status_load_q;
    assign status_o      = status_q;
    assign op_prio_o     = op_prio_q;
    assign priv_o        = priv_q;
    assign ovf_err_o     = ovf_q;
endmodule

// File: rtl/exc_sequencer_chk.sv
// Checker for exc_sequencer, attached by bind. Observes ports only.
module exc_sequencer_chk #(
    parameter int N_EXC  = 8,
    parameter int PRIO_W = 3,
    parameter int AW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [AW-1:0]     mem_addr_o,
    input logic              mem_ready_i,
    input logic              pc_load_o,
    input logic              status_load_o,
    input logic [PRIO_W-1:0] op_prio_o,
    input logic              priv_o,
    input logic              busy_o,
    input logic              ovf_err_o
);
    // R1 R5: an entry load always raises priority and enters privileged mode
    a_r5_entry_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !status_load_o) |-> (op_prio_o > $past(op_prio_o)) && priv_o);

    // R3: a PC change follows a completed read (vector or frame PC)
    a_r3_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(mem_req_o && !mem_we_o && mem_ready_i));

    // R4: the load strobe lasts one cycle
    a_r4_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    // R11: a stalled request keeps address and direction
    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R11: memory traffic only inside a sequence
    a_r11_mem_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R10: overflow flag is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    // R6: status restore comes with a PC load once idle
    a_r6_status_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
        status_load_o |-> (pc_load_o && !busy_o));
endmodule

bind exc_sequencer exc_sequencer_chk #(
    .N_EXC  (N_EXC),
    .PRIO_W (PRIO_W),
    .AW     (AW)
) u_chk (.*);

// File: tb/tb_exc_sequencer.sv
`timescale 1ns/1ps
module tb_exc_sequencer;
    localparam int N_EXC  = 8;
    localparam int PRIO_W = 3;
    localparam int AW     = 32;
    localparam int PRIO_TAB [N_EXC] = '{2, 5, 5, 1, 7, 3, 7, 0};
    // {request mask[11:4], expected winner[3:0]}, winner 0xF = none taken
    localparam logic [11:0] ARB_TAB [7] = '{
        12'h010, 12'h061, 12'h504, 12'h285, 12'h80F, 12'hFF4, 12'h090
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_EXC-1:0]        exc_req = '0;
    logic [N_EXC*PRIO_W-1:0] exc_prio;
    logic [AW-1:0]           vec_base = '0;
    logic                    ret_req = 1'b0;
    logic [31:0]             cur_pc = '0;
    logic [31:0]             cur_status = '0;
    logic                    mem_req, mem_we, mem_ready;
    logic [AW-1:0]           mem_addr;
    logic [31:0]             mem_wdata, mem_rdata;
    logic                    pc_load, status_load, priv, busy, ovf_err;
    logic [31:0]             pc, status;
    logic [PRIO_W-1:0]       op_prio;

    logic        stall = 1'b0;
    logic [3:0]  tick;
    logic [31:0] ram [128];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];
    int          log_n;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    initial begin
        for (int i = 0; i < N_EXC; i++) exc_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(PRIO_TAB[i]);
    end

    exc_sequencer dut (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_prio_i(exc_prio),
        .vec_base_i(vec_base), .ret_req_i(ret_req), .cur_pc_i(cur_pc),
        .cur_status_i(cur_status), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
        .mem_rdata_i(mem_rdata), .pc_load_o(pc_load), .pc_o(pc),
        .status_load_o(status_load), .status_o(status), .op_prio_o(op_prio),
        .priv_o(priv), .busy_o(busy), .ovf_err_o(ovf_err)
    );

    // Memory model: vector slots computed below 0x80, stack RAM above.
    always @(posedge clk) tick <= tick + 4'd1;
    initial tick = '0;
    assign mem_ready = stall ? tick[0] : 1'b1;
    assign mem_rdata = (mem_addr < 32'h80) ? (32'h1000 + (((mem_addr >> 2) - 32'd16) << 4))
                                           : ram[mem_addr[8:2]];
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) ram[mem_addr[8:2]] <= mem_wdata;
        if (!rst_n) log_n <= 0;
        else if (mem_req && mem_ready && log_n < 64) begin
            log_addr[log_n] <= mem_addr;
            log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
            log_we[log_n]   <= mem_we;
            log_n           <= log_n + 1;
        end
    end

    function automatic logic [31:0] hpc(int n);
        return 32'h1000 + 32'(n) * 32'h10;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exc_req = '0; ret_req = 1'b0; stall = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_req(logic [N_EXC-1:0] m);
        @(negedge clk); exc_req = m;
        @(negedge clk); exc_req = '0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); ret_req = 1'b1;
        @(negedge clk); ret_req = 1'b0;
    endtask

    task automatic wait_load(int lim, output bit got, output int nb);
        got = 0; nb = 0;
        for (int k = 0; k < lim; k++) begin
            if (pc_load) begin got = 1; break; end
            if (busy) nb++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(int n, output bit any);
        any = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (busy || pc_load || mem_req) any = 1;
        end
    endtask

    initial begin
        bit got, any;
        int nb;
        do_reset();
        @(negedge clk);
        // R12 reset state
        chk(!busy, "R12 busy", 32'(busy), 0);
        chk(op_prio == 0 && !priv, "R12 prio/mode", 32'(op_prio), 0);
        chk(!ovf_err && !mem_req && !pc_load, "R12 flags", {ovf_err, mem_req, pc_load}, 0);

        // R2 R1 R4 R5: arbitration table
        for (int r = 0; r < 7; r++) begin
            logic [7:0] m;
            int w;
            m = ARB_TAB[r][11:4];
            w = int'(ARB_TAB[r][3:0]);
            do_reset();
            pulse_req(m);
            wait_load(20, got, nb);
            if (w == 15) begin
                chk(!got, "R1 prio0 not taken", 32'(got), 0);
                chk(op_prio == 0, "R1 prio stays", 32'(op_prio), 0);
            end else begin
                chk(got && pc == hpc(w), "R2 winner pc", pc, hpc(w));
                chk(op_prio == PRIO_W'(PRIO_TAB[w]), "R5 op prio", 32'(op_prio), 32'(PRIO_TAB[w]));
                chk(priv, "R5 privileged", 32'(priv), 1);
            end
        end

        // R3 R4 R11: frame layout, order and entry length
        do_reset();
        cur_pc = 32'hAAAA0000; cur_status = 32'h5A5A;
        pulse_req(8'h01);
        wait_load(40, got, nb);
        chk(got && pc == 32'h1000, "R4 vector pc", pc, 32'h1000);
        chk(nb == 4, "R11 entry busy cycles", 32'(nb), 4);
        chk(log_n == 4, "R3 access count", 32'(log_n), 4);
        chk(log_we[0] && log_addr[0] == 32'hFC && log_data[0] == 32'hAAAA0000, "R3 pc slot", log_data[0], 32'hAAAA0000);
        chk(log_we[1] && log_addr[1] == 32'hF8 && log_data[1] == 32'h5A5A, "R3 status slot", log_data[1], 32'h5A5A);
        chk(log_we[2] && log_addr[2] == 32'hF4 && log_data[2] == 32'h0, "R3 meta slot", log_addr[2], 32'hF4);
        chk(!log_we[3] && log_addr[3] == 32'h40, "R4 vector addr", log_addr[3], 32'h40);

        // R8: nesting with exc5 (prio 3) over exc0 (prio 2)
        cur_pc = 32'hBBBB0000; cur_status = 32'h11;
        pulse_req(8'h20);
        wait_load(40, got, nb);
        chk(got && pc == hpc(5), "R8 nested pc", pc, hpc(5));
        chk(op_prio == 3, "R8 nested prio", 32'(op_prio), 3);
        chk(log_data[6] == 32'h80000002 && log_addr[6] == 32'hE8, "R3 nested meta", log_data[6], 32'h80000002);
        // R1: lower priority exc3 stays pending
        pulse_req(8'h08);
        quiet(10, any);
        chk(!any, "R1 lower not taken", 32'(any), 0);
        cur_pc = 32'hCCCC0000;
        // R6: first return
        pulse_ret();
        wait_load(40, got, nb);
        chk(got && pc == 32'hBBBB0000, "R6 restored pc", pc, 32'hBBBB0000);
        chk(status_load && status == 32'h11, "R6 restored status", status, 32'h11);
        chk(op_prio == 2 && priv, "R6 restored prio/mode", {op_prio, priv}, {3'd2, 1'b1});
        chk(nb == 3, "R11 return busy cycles", 32'(nb), 3);
        pulse_ret();
        wait_load(40, got, nb);
        chk(got && pc == 32'hAAAA0000 && status == 32'h5A5A, "R6 outer pc", pc, 32'hAAAA0000);
        chk(op_prio == 0 && !priv, "R6 outer prio/mode", {op_prio, priv}, 0);
        // R9: the held exc3 is now taken
        @(negedge clk);
        wait_load(40, got, nb);
        chk(got && pc == hpc(3) && op_prio == 1, "R9 pending taken", pc, hpc(3));
        pulse_ret();
        wait_load(40, got, nb);
        quiet(15, any);
        chk(!any && op_prio == 0, "R9 not retaken", 32'(any), 0);

        // R8: equal priority does not preempt
        do_reset();
        pulse_req(8'h02);
        wait_load(40, got, nb);
        pulse_req(8'h04);
        quiet(12, any);
        chk(!any && op_prio == 5 && pc == hpc(1), "R8 equal no preempt", 32'(any), 0);

        // R7: return with empty stack
        do_reset();
        pulse_ret();
        quiet(10, any);
        chk(!any && log_n == 0, "R7 empty return ignored", 32'(log_n), 0);

        // R9 R11: request latched during a stalled sequence
        do_reset();
        stall = 1'b1;
        pulse_req(8'h01);
        while (!busy) @(negedge clk);
        pulse_req(8'h10);
        wait_load(60, got, nb);
        chk(got && pc == hpc(0), "R11 stalled entry pc", pc, hpc(0));
        @(negedge clk);
        wait_load(60, got, nb);
        chk(got && pc == hpc(4) && op_prio == 7, "R9 latched taken", pc, hpc(4));
        chk(log_data[6] == 32'h80000002, "R3 stalled meta", log_data[6], 32'h80000002);
        stall = 1'b0;

        // R10: overflow on the fifth frame
        do_reset();
        pulse_req(8'h08); wait_load(40, got, nb);
        pulse_req(8'h01); wait_load(40, got, nb);
        pulse_req(8'h20); wait_load(40, got, nb);
        pulse_req(8'h02); wait_load(40, got, nb);
        chk(op_prio == 5 && !ovf_err, "R10 four frames fit", 32'(op_prio), 5);
        pulse_req(8'h10);
        quiet(10, any);
        chk(!any && ovf_err && op_prio == 5, "R10 overflow refused", 32'(ovf_err), 1);
        pulse_ret();
        wait_load(40, got, nb);
        chk(got && op_prio == 3, "R10 return after overflow", 32'(op_prio), 3);
        quiet(10, any);
        chk(!any && ovf_err, "R10 blocked while flagged", 32'(any), 0);
        do_reset();
        @(negedge clk);
        chk(!ovf_err, "R12 flag cleared by reset", 32'(ovf_err), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog expired act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule